// File: doc/BRIEF.md
# Byte-Wide Two-Wire Serial Engine

This block shifts single 8-bit frames over a two-wire open-drain bus (SCL, SDA). It can run as bus master, where it makes SCL from an internal 8-bit divider, or as a slave, where the bit clock comes from the SCL pin. Data leaves and arrives most significant bit first. A ninth clock carries the acknowledge bit. A frame is loaded from a one-entry transmit buffer. When receiving, the bits are read from the bus while the engine sends a dummy all-ones frame, and the result goes into a one-entry receive buffer.

The engine watches the bus for start and stop conditions and for the acknowledge bit, and raises an interrupt pulse for each of these. It flags an overrun when a new frame reaches its eighth bit before the previous frame has been read. As master transmitter it detects loss of arbitration. Once lost, it lets go of both lines for the rest of the frame, and software can choose whether the lost flag is set at the sampling edge or at the following falling edge. The SDA output has a programmable digital delay and is only updated while the synchronized SCL is low.

Top module: `i2c_byte_engine`

## Requirements
- R1: A frame is 8 data bits sent most significant bit first, followed by a ninth clock for the acknowledge bit. In master mode, the byte taken from the transmit buffer appears on SDA at the eight rising SCL edges.
- R2: In master mode, SCL has a period of 2×(div_n+1) clk cycles. Each half-period lasts div_n+1 cycles. Before and after a frame, SCL is released (scl_oe=0).
- R3: A frame starts only when tx_en=1 and the transmit buffer holds data (tb_empty=0). Starting a frame sets tb_empty to 1.
- R4: A received byte is stored only when rx_en=1. Reception needs tx_en=1 and a loaded transmit buffer; with either missing, no clock is produced. When a frame completes with rx_en=1, rb_data holds the sampled byte and rb_full=1. During the ninth clock the engine pulls SDA low.
- R5: On the ninth rising SCL edge the engine samples SDA. Low gives an acknowledge event (evt bit 2); high gives a no-acknowledge event (evt bit 3). Each event is a one-cycle pulse, and irq is the OR of all evt bits.
- R6: SDA falling while SCL is high gives a start event (evt bit 0). SDA rising while SCL is high gives a stop event (evt bit 1).
- R7: If rb_full=1 when the eighth bit of a received frame is sampled, ovr is set and that frame raises no acknowledge or no-acknowledge event. A rb_rd pulse clears both rb_full and ovr.
- R8: sda_oe changes only while the synchronized SCL is low. Counted from the clk edge after SCL falls at the pin, it follows 3+D cycles later, where D=0 for dly_sel=0 and D=dly_sel+1 otherwise.
- R9: Arbitration is lost when a master transmitter (rx_en=0) has released SDA during a data bit but samples SDA low. The engine then releases SDA and SCL for the rest of the frame. With abt_late=0, abt is set at that sampling edge; with abt_late=1, it is set at the next SCL falling edge. The next frame start clears abt.
- R10: In slave mode (master_sel=0), the bits move on the SCL pin edges and scl_oe is never asserted.
- R11: After reset: scl_oe=0, sda_oe=0, tb_empty=1, rb_full=0, ovr=0, abt=0, evt=0, irq=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Count-source clock |
| rst_n | input | 1 | Active-low reset |
| master_sel | input | 1 | 1: internal SCL generation, 0: SCL from pin |
| tx_en | input | 1 | Transmit enable |
| rx_en | input | 1 | Receive enable |
| div_n | input | 8 | Divider setting n |
| dly_sel | input | 3 | SDA delay select |
| abt_late | input | 1 | Arbitration flag timing select |
| tb_wr | input | 1 | Write strobe for the transmit buffer |
| tb_data | input | 8 | Transmit buffer write data |
| tb_empty | output | 1 | Transmit buffer holds no unsent byte |
| rb_rd | input | 1 | Read strobe for the receive buffer |
| rb_data | output | 8 | Receive buffer |
| rb_full | output | 1 | Receive buffer holds an unread byte |
| ovr | output | 1 | Overrun flag |
| abt | output | 1 | Arbitration-lost flag |
| evt | output | 4 | Event pulses: start, stop, ack, nack |
| irq | output | 1 | Interrupt request pulse |
| scl_i | input | 1 | SCL pin level |
| sda_i | input | 1 | SDA pin level |
| scl_oe | output | 1 | Pull SCL low |
| sda_oe | output | 1 | Pull SDA low |

## Verification
The assertions assume that master_sel, rx_en, dly_sel and div_n stay constant for the whole of a frame. They also assume that every SCL half-period lasts longer than the synchronizer latency plus the chosen SDA delay, so that SDA settles while SCL is still low. The stimulus changes these controls only while reset is asserted. The master tests use a divider of 9, which gives 10-cycle half-periods, and the bench holds every SCL phase it drives for at least 10 cycles. The bench changes SDA only while SCL is low, except when it deliberately makes start and stop conditions.

// File: rtl/i2cb_pkg.sv
`timescale 1ns/1ps
package i2cb_pkg;
  localparam int unsigned FRAME_BITS = 8;
  localparam int unsigned EVT_W      = 4;
  localparam int unsigned EV_START   = 0;
  localparam int unsigned EV_STOP    = 1;
  localparam int unsigned EV_ACK     = 2;
  localparam int unsigned EV_NACK    = 3;

  // SDA hold-off in count-source cycles for a delay select code
  function automatic int unsigned sda_delay_cycles(input int unsigned sel);
    return (sel == 0) ? 0 : sel + 1;
  endfunction
endpackage

// File: rtl/i2cb_sync.sv
`timescale 1ns/1ps
module i2cb_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic scl_m, scl_p, sda_m, sda_p;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_m <= 1'b1; scl_s <= 1'b1; scl_p <= 1'b1;
      sda_m <= 1'b1; sda_s <= 1'b1; sda_p <= 1'b1;
    end else begin
      scl_m <= scl_i; scl_s <= scl_m; scl_p <= scl_s;
      sda_m <= sda_i; sda_s <= sda_m; sda_p <= sda_s;
    end
  end

  assign scl_rise  = scl_s & ~scl_p;
  assign scl_fall  = ~scl_s & scl_p;
  assign start_det = scl_s & scl_p & sda_p & ~sda_s;
  assign stop_det  = scl_s & scl_p & ~sda_p & sda_s;
endmodule

// File: rtl/i2cb_sclgen.sv
`timescale 1ns/1ps
module i2cb_sclgen #(
  parameter int unsigned DIV_W  = 8,
  parameter int unsigned NCLK   = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             abort,
  input  logic [DIV_W-1:0] div_n,
  output logic             scl_low
);
  localparam int unsigned HP_LAST = 2 * NCLK;
  localparam int unsigned HP_W    = $clog2(HP_LAST + 1);

  logic [DIV_W-1:0] cnt;
  logic [HP_W-1:0]  hp;
  logic             run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0; hp <= '0; run <= 1'b0; scl_low <= 1'b0;
    end else if (abort) begin
      run <= 1'b0; scl_low <= 1'b0;
    end else if (start) begin
      run <= 1'b1; scl_low <= 1'b1; cnt <= '0; hp <= '0;
    end else if (run) begin
      if (cnt == div_n) begin
        cnt <= '0;
        hp  <= hp + 1'b1;
        if (hp == HP_W'(HP_LAST)) begin
          run     <= 1'b0;
          scl_low <= 1'b0;
        end else begin
          scl_low <= ~scl_low;
        end
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/i2cb_sdadly.sv
`timescale 1ns/1ps
module i2cb_sdadly
  import i2cb_pkg::*;
#(
  parameter int unsigned DLY_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl_s,
  input  logic             want,
  input  logic [DLY_W-1:0] dly_sel,
  output logic             sda_oe
);
  localparam int unsigned MAXD  = (1 << DLY_W);
  localparam int unsigned CNT_W = $clog2(MAXD + 1);

  logic [CNT_W-1:0] low_cnt;
  logic [CNT_W-1:0] need;

  assign need = CNT_W'(sda_delay_cycles(32'(dly_sel)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_cnt <= '0;
      sda_oe  <= 1'b0;
    end else begin
      if (scl_s)                low_cnt <= '0;
      else if (low_cnt != '1)   low_cnt <= low_cnt + 1'b1;
      if (!scl_s && low_cnt >= need) sda_oe <= want;
    end
  end
endmodule

// File: rtl/i2c_byte_engine.sv
`timescale 1ns/1ps
module i2c_byte_engine
  import i2cb_pkg::*;
#(
  parameter int unsigned DIV_W = 8,
  parameter int unsigned DLY_W = 3
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  master_sel,
  input  logic                  tx_en,
  input  logic                  rx_en,
  input  logic [DIV_W-1:0]      div_n,
  input  logic [DLY_W-1:0]      dly_sel,
  input  logic                  abt_late,
  input  logic                  tb_wr,
  input  logic [FRAME_BITS-1:0] tb_data,
  output logic                  tb_empty,
  input  logic                  rb_rd,
  output logic [FRAME_BITS-1:0] rb_data,
  output logic                  rb_full,
  output logic                  ovr,
  output logic                  abt,
  output logic [EVT_W-1:0]      evt,
  output logic                  irq,
  input  logic                  scl_i,
  input  logic                  sda_i,
  output logic                  scl_oe,
  output logic                  sda_oe
);
  localparam int unsigned BC_W = $clog2(FRAME_BITS + 1);

  // named internal events (also seen by the checker)
  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic go, lose_now;

  logic [FRAME_BITS-1:0] tb_q, sh, rx_sh;
  logic [BC_W-1:0]       bit_cnt;
  logic tb_full, active, armed, want, lost, ovr_byte, abt_pend, rxm, msm;

  i2cb_sync u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  assign go       = !active && tx_en && tb_full;
  assign lose_now = active && scl_rise && msm && !rxm && !lost &&
                    (bit_cnt < BC_W'(FRAME_BITS)) && !want && !sda_s;

  i2cb_sclgen #(.DIV_W(DIV_W), .NCLK(FRAME_BITS + 1)) u_scl (
    .clk(clk), .rst_n(rst_n), .start(go && master_sel), .abort(lose_now),
    .div_n(div_n), .scl_low(scl_oe)
  );

  i2cb_sdadly #(.DLY_W(DLY_W)) u_dly (
    .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .want(want),
    .dly_sel(dly_sel), .sda_oe(sda_oe)
  );

  assign tb_empty = !tb_full;
  assign irq      = |evt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tb_q <= '0; sh <= '0; rx_sh <= '0; rb_data <= '0; bit_cnt <= '0;
      tb_full <= 1'b0; active <= 1'b0; armed <= 1'b0; want <= 1'b0;
      lost <= 1'b0; ovr_byte <= 1'b0; abt_pend <= 1'b0; rxm <= 1'b0;
      msm <= 1'b0; rb_full <= 1'b0; ovr <= 1'b0; abt <= 1'b0; evt <= '0;
    end else begin
      evt <= '0;
      evt[EV_START] <= start_det;
      evt[EV_STOP]  <= stop_det;
      if (rb_rd) begin
        rb_full <= 1'b0;
        ovr     <= 1'b0;
      end
      if (go) tb_full <= 1'b0;
      if (tb_wr) begin
        tb_q    <= tb_data;
        tb_full <= 1'b1;
      end
      if (go) begin
        active <= 1'b1; armed <= 1'b0; sh <= tb_q; bit_cnt <= '0;
        want <= ~tb_q[FRAME_BITS-1]; lost <= 1'b0; ovr_byte <= 1'b0;
        abt <= 1'b0; abt_pend <= 1'b0; rxm <= rx_en; msm <= master_sel;
      end else if (active) begin
        if (scl_rise) begin
          armed <= 1'b1;
          if (bit_cnt < BC_W'(FRAME_BITS)) begin
            rx_sh <= {rx_sh[FRAME_BITS-2:0], sda_s};
            if (lose_now) begin
              lost <= 1'b1;
              want <= 1'b0;
              if (abt_late) abt_pend <= 1'b1;
              else          abt      <= 1'b1;
            end
            if (bit_cnt == BC_W'(FRAME_BITS - 1) && rxm && rb_full) begin
              ovr      <= 1'b1;
              ovr_byte <= 1'b1;
            end
          end else begin
            if (!ovr_byte) begin
              evt[EV_ACK]  <= !sda_s;
              evt[EV_NACK] <= sda_s;
            end
            if (rxm) begin
              rb_data <= rx_sh;
              rb_full <= 1'b1;
            end
          end
        end
        if (scl_fall && armed) begin
          if (abt_pend) begin
            abt      <= 1'b1;
            abt_pend <= 1'b0;
          end
          if (bit_cnt == BC_W'(FRAME_BITS)) begin
            active <= 1'b0;
            want   <= 1'b0;
          end else begin
            bit_cnt <= bit_cnt + 1'b1;
            sh      <= {sh[FRAME_BITS-2:0], 1'b0};
            if (lost)                                   want <= 1'b0;
            else if (bit_cnt == BC_W'(FRAME_BITS - 1))  want <= rxm;
            else                                        want <= ~sh[FRAME_BITS-2];
          end
        end
      end
    end
  end
endmodule

// File: rtl/i2cb_chk.sv
`timescale 1ns/1ps
module i2cb_chk (
  input logic clk,
  input logic rst_n,
  input logic master_sel,
  input logic tx_en,
  input logic tb_empty,
  input logic scl_oe,
  input logic sda_oe,
  input logic rb_full,
  input logic ovr,
  input logic scl_s,
  input logic active,
  input logic lost
);
  // R8
  sda_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> !$past(scl_s));

  // R9
  lost_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lost |-> (!scl_oe && !sda_oe));

  // R7
  ovr_needs_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovr |-> rb_full);

  // R3
  start_cond_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(active) |-> $past(tx_en && !tb_empty));

  // R10
  slave_no_scl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !master_sel |-> !scl_oe);

  // R4
  rb_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rb_full) |-> $past(active));
endmodule

bind i2c_byte_engine i2cb_chk u_chk (
  .clk(clk), .rst_n(rst_n), .master_sel(master_sel), .tx_en(tx_en),
  .tb_empty(tb_empty), .scl_oe(scl_oe), .sda_oe(sda_oe), .rb_full(rb_full),
  .ovr(ovr), .scl_s(scl_s), .active(active), .lost(lost)
);

// File: tb/sim_i2c_byte_engine.sv
`timescale 1ns/1ps
module sim_i2c_byte_engine;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic master_sel = 1'b1, tx_en = 1'b0, rx_en = 1'b0, abt_late = 1'b0;
  logic [7:0] div_n = 8'd9;
  logic [2:0] dly_sel = 3'd0;
  logic tb_wr = 1'b0, rb_rd = 1'b0;
  logic [7:0] tb_data = 8'h00;
  logic tb_empty, rb_full, ovr, abt, irq, scl_oe, sda_oe;
  logic [7:0] rb_data;
  logic [3:0] evt;
  logic bscl_low = 1'b0, bsda_low = 1'b0;
  wire scl_i = ~(scl_oe | bscl_low);
  wire sda_i = ~(sda_oe | bsda_low);

  int total = 0, fails = 0, cyc = 0;
  int ev_cnt [4];
  int irq_cnt;
  logic scl_seen;

  always #5 clk = ~clk;

  i2c_byte_engine u0 (
    .clk(clk), .rst_n(rst_n), .master_sel(master_sel), .tx_en(tx_en),
    .rx_en(rx_en), .div_n(div_n), .dly_sel(dly_sel), .abt_late(abt_late),
    .tb_wr(tb_wr), .tb_data(tb_data), .tb_empty(tb_empty), .rb_rd(rb_rd),
    .rb_data(rb_data), .rb_full(rb_full), .ovr(ovr), .abt(abt), .evt(evt),
    .irq(irq), .scl_i(scl_i), .sda_i(sda_i), .scl_oe(scl_oe), .sda_oe(sda_oe)
  );

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < 4; k++) ev_cnt[k] <= 0;
      irq_cnt <= 0; scl_seen <= 1'b0;
    end else begin
      for (int k = 0; k < 4; k++) if (evt[k]) ev_cnt[k] <= ev_cnt[k] + 1;
      if (irq) irq_cnt <= irq_cnt + 1;
      if (scl_oe) scl_seen <= 1'b1;
    end
  end

  task automatic summary();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      total++; fails++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      summary();
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset(input bit ms, input bit rx, input [2:0] ds, input bit late);
    @(negedge clk);
    rst_n = 1'b0; master_sel = ms; rx_en = rx; dly_sel = ds; abt_late = late;
    tx_en = 1'b1; div_n = 8'd9; tb_wr = 1'b0; rb_rd = 1'b0;
    bscl_low = 1'b0; bsda_low = 1'b0;
    wait_clk(3);
    rst_n = 1'b1;
    wait_clk(2);
  endtask

  task automatic write_tb(input [7:0] d);
    @(negedge clk); tb_wr = 1'b1; tb_data = d;
    @(negedge clk); tb_wr = 1'b0;
  endtask

  // bench acts as the far end of a master-mode frame
  task automatic m_xfer(input [7:0] txb, input [7:0] sbits, input bit drive,
                        input bit back, output [7:0] seen, output bit seen_ack,
                        output int per);
    time t0, t1;
    t0 = 0; t1 = 0;
    write_tb(txb);
    @(negedge scl_i);
    bsda_low = drive & ~sbits[7];
    for (int i = 0; i < 9; i++) begin
      @(posedge scl_i);
      if (i == 0) t0 = $time;
      if (i == 1) t1 = $time;
      if (i < 8) seen[7-i] = sda_i; else seen_ack = ~sda_i;
      @(negedge scl_i);
      if (i < 7)       bsda_low = drive & ~sbits[6-i];
      else if (i == 7) bsda_low = back;
      else             bsda_low = 1'b0;
    end
    per = int'((t1 - t0) / 10);
    wait_clk(30);
  endtask

  // bench clocks a slave frame; SCL is low on entry and on exit
  task automatic s_clock(input bit back, output [7:0] seen);
    for (int i = 0; i < 9; i++) begin
      if (i == 8) bsda_low = back;
      wait_clk(10); bscl_low = 1'b0;
      wait_clk(5);  if (i < 8) seen[7-i] = sda_i;
      wait_clk(5);  bscl_low = 1'b1;
    end
    wait_clk(3); bsda_low = 1'b0;
    wait_clk(10);
  endtask

  task automatic t_reset();
    do_reset(1'b1, 1'b0, 3'd0, 1'b0);
    chk("R11 scl_oe", scl_oe, 0);
    chk("R11 sda_oe", sda_oe, 0);
    chk("R11 tb_empty", tb_empty, 1);
    chk("R11 rb_full", rb_full, 0);
    chk("R11 ovr/abt", {ovr, abt}, 0);
    chk("R11 evt/irq", {evt, irq}, 0);
  endtask

  task automatic t_master_tx_ack();
    logic [7:0] s; bit a; int p;
    do_reset(1'b1, 1'b0, 3'd0, 1'b0);
    m_xfer(8'hA5, 8'h00, 1'b0, 1'b1, s, a, p);
    chk("R1 master byte on SDA", s, 8'hA5);
    chk("R2 SCL period", p, 20);
    chk("R2 SCL released after frame", scl_oe, 0);
    chk("R3 tb_empty after start", tb_empty, 1);
    chk("R5 ack events", ev_cnt[2], 1);
    chk("R5 nack events", ev_cnt[3], 0);
  endtask

  task automatic t_master_tx_nack();
    logic [7:0] s; bit a; int p;
    do_reset(1'b1, 1'b0, 3'd0, 1'b0);
    m_xfer(8'h3C, 8'h00, 1'b0, 1'b0, s, a, p);
    chk("R1 master byte 3C", s, 8'h3C);
    chk("R5 nack events", ev_cnt[3], 1);
    chk("R5 ack events", ev_cnt[2], 0);
    chk("R5 irq pulses", irq_cnt, 1);
  endtask

  task automatic t_tx_gate();
    do_reset(1'b1, 1'b0, 3'd0, 1'b0);
    tx_en = 1'b0;
    write_tb(8'h55);
    wait_clk(100);
    chk("R3 no clock without tx_en", scl_seen, 0);
    chk("R3 tb held", tb_empty, 0);
    tx_en = 1'b1;
    wait_clk(2);
    chk("R3 start once enabled", scl_oe, 1);
  endtask

  task automatic t_rx_gate();
    do_reset(1'b1, 1'b1, 3'd0, 1'b0);
    wait_clk(100);
    chk("R4 no clock without tb data", scl_seen, 0);
    do_reset(1'b1, 1'b1, 3'd0, 1'b0);
    tx_en = 1'b0;
    write_tb(8'hFF);
    wait_clk(100);
    chk("R4 no clock with rx_en but no tx_en", scl_seen, 0);
    chk("R4 nothing received", rb_full, 0);
  endtask

  task automatic t_rx_and_overrun();
    logic [7:0] s; bit a; int p;
    do_reset(1'b1, 1'b1, 3'd0, 1'b0);
    m_xfer(8'hFF, 8'hC3, 1'b1, 1'b0, s, a, p);
    chk("R4 rb_data", rb_data, 8'hC3);
    chk("R4 rb_full", rb_full, 1);
    chk("R4 engine drives ACK", a, 1);
    chk("R5 ack event on receive", ev_cnt[2], 1);
    chk("R7 no overrun yet", ovr, 0);
    m_xfer(8'hFF, 8'h81, 1'b1, 1'b0, s, a, p);
    chk("R7 overrun flagged", ovr, 1);
    chk("R7 no ack/nack event on overrun", ev_cnt[2] + ev_cnt[3], 1);
    chk("R7 rb_full kept", rb_full, 1);
    @(negedge clk); rb_rd = 1'b1; @(negedge clk); rb_rd = 1'b0;
    chk("R7 read clears rb_full and ovr", {rb_full, ovr}, 0);
  endtask

  task automatic lose_at_bit2();
    write_tb(8'hFF);
    @(negedge scl_i);
    for (int i = 0; i < 2; i++) begin
      @(posedge scl_i); @(negedge scl_i);
    end
    bsda_low = 1'b1;
    @(posedge scl_i);
  endtask

  task automatic t_arb_early();
    bit held;
    do_reset(1'b1, 1'b0, 3'd0, 1'b0);
    lose_at_bit2();
    wait_clk(8);
    chk("R9 abt at sampling edge", abt, 1);
    chk("R9 lines released", {scl_oe, sda_oe}, 0);
    held = 1'b1;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk); if (!scl_i) held = 1'b0;
    end
    chk("R9 no more SCL from engine", held, 1);
    bscl_low = 1'b1; wait_clk(5); bsda_low = 1'b0; wait_clk(5);
    for (int i = 0; i < 6; i++) begin
      bscl_low = 1'b0; wait_clk(10); bscl_low = 1'b1; wait_clk(10);
    end
    bscl_low = 1'b0; wait_clk(10);
    write_tb(8'h00);
    wait_clk(3);
    chk("R9 abt cleared by next start", abt, 0);
  endtask

  task automatic t_arb_late();
    do_reset(1'b1, 1'b0, 3'd0, 1'b1);
    lose_at_bit2();
    wait_clk(8);
    chk("R9 late abt not yet set", abt, 0);
    bscl_low = 1'b1;
    wait_clk(8);
    chk("R9 late abt at falling edge", abt, 1);
  endtask

  task automatic t_slave();
    logic [7:0] s;
    do_reset(1'b0, 1'b0, 3'd0, 1'b0);
    bsda_low = 1'b1; wait_clk(6);
    chk("R6 start event", ev_cnt[0], 1);
    bscl_low = 1'b1; wait_clk(4); bsda_low = 1'b0;
    write_tb(8'h5A);
    s_clock(1'b1, s);
    chk("R10 slave byte", s, 8'h5A);
    chk("R5 slave ack event", ev_cnt[2], 1);
    chk("R10 scl_oe never driven", scl_seen, 0);
    bsda_low = 1'b1; wait_clk(5); bscl_low = 1'b0; wait_clk(10);
    bsda_low = 1'b0; wait_clk(6);
    chk("R6 stop event", ev_cnt[1], 1);
    chk("R6 irq count", irq_cnt, 3);
  endtask

  task automatic t_delay(input [2:0] ds, input int exp);
    int k;
    do_reset(1'b0, 1'b0, ds, 1'b0);
    write_tb(8'h00);
    wait_clk(10);
    chk("R8 SDA held while SCL high", sda_oe, 0);
    bscl_low = 1'b1;
    k = 0;
    for (int i = 0; i < 20; i++) begin
      @(posedge clk); k++;
      @(negedge clk);
      if (sda_oe) break;
    end
    chk("R8 SDA delay cycles", k, exp);
  endtask

  initial begin
    t_reset();
    t_master_tx_ack();
    t_master_tx_nack();
    t_tx_gate();
    t_rx_gate();
    t_rx_and_overrun();
    t_arb_early();
    t_arb_late();
    t_slave();
    t_delay(3'd0, 3);
    t_delay(3'd5, 9);
    summary();
  end
endmodule